// File: doc/BRIEF.md
# Shared-Counter Rolling Shutter Transfer Generator

This block drives the charge-transfer gates of a pixel array that is read in rolling order. Each row has a transfer line (`tx_o`) and a drain line (`txd_o`). All rows share one timer that makes a periodic modulation pulse with a programmable period and high time. A pair of sequencing counters opens a strobe window for each row in turn. Each window lasts a programmable number of pulse periods, and the start of each window is a fixed programmable gap after the start of the window before it. A row's transfer line is the AND of the shared pulse and its own strobe. Its drain line is always the complement of the transfer line, so charge drains whenever the row is not transferring.

A single-cycle `start_i` launches a frame. The block samples the timing inputs on that same edge and ignores them, and any further `start_i`, until the frame is over. A programmable phase offset delays the shared pulse by a whole number of clock cycles, which lets the caller produce the four sampling phases of a continuous-wave depth measurement. When the last row's window has closed, the block raises `done_o` for one cycle and then returns to idle.

Top module: `rolling_tx_gen`

## Requirements
- R1: After reset, and while idle, every `tx_o` bit is 0, every `txd_o` bit is 1 and `done_o` is 0.
- R2: Let k = 0 be the first clock cycle after the edge that accepts `start_i`. The shared pulse is high in cycle k exactly when ((k − phase) mod period) < high, where phase, period and high are the values sampled at start.
- R3: Row r (row 0 first, ascending) has its strobe open exactly in cycles r·gap ≤ k < r·gap + pulses·period.
- R4: `tx_o[r]` is the AND of the shared pulse and the strobe of row r. `txd_o[r]` is the inverse of `tx_o[r]` in every cycle, so it is high outside the window.
- R5: `done_o` is high for exactly the one cycle k = (ROWS−1)·gap + pulses·period, the first cycle after the last row's window closes. All `tx_o` bits are 0 in that cycle, and the block is idle from the next cycle on.
- R6: A start is ignored, with no `tx_o` pulse and no `done_o`, when high = 0, period ≤ high, gap = 0, pulses = 0 or phase ≥ period.
- R7: While a frame is running, changes on the timing inputs and further `start_i` pulses have no effect on the outputs.
- R8: Once `done_o` has been given, a new valid start is accepted and produces a complete frame again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request, sampled while idle |
| high_i | input | CW | Pulse high time in clock cycles |
| period_i | input | CW | Pulse period in clock cycles |
| gap_i | input | CW | Delay between the window starts of neighbouring rows, in cycles |
| pulses_i | input | NW | Window length per row, in pulse periods |
| phase_i | input | CW | Delay of the shared pulse, in cycles |
| tx_o | output | ROWS | Per-row transfer gate |
| txd_o | output | ROWS | Per-row drain gate |
| done_o | output | 1 | One-cycle frame completion |

## Verification
The hardest situation to reach is an overlap in which several rows have their windows open while the phase-shifted pulse wraps at a point that is not aligned with any window edge. This is where a wrong launch or retire count, or a wrong phase preload, would show up. The stimulus sweeps every legal combination of high time, period and phase on a small array, for gaps both shorter and longer than a period and for window lengths of one and two periods. It compares the full row vector in every cycle of every frame against values computed arithmetically. Some of these frames receive a burst of changed timing inputs and a second start in the middle of the frame.

// File: rtl/rolling_tx_pkg.sv
package rolling_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } frame_state_e;

endpackage

// File: rtl/rtx_pulse_timer.sv
module rtx_pulse_timer #(
   parameter int CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic          run_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] high_i,
   input  logic [CW-1:0] phase_i,
   output logic          pulse_o
);

   logic [CW-1:0] per_q;
   logic [CW-1:0] high_q;
   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == per_q - CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q  <= '0;
         high_q <= '0;
         cnt_q  <= '0;
      end else if (load_i) begin
         per_q  <= period_i;
         high_q <= high_i;
         cnt_q  <= (phase_i == '0) ? '0 : (period_i - phase_i);
      end else if (run_i) begin
         cnt_q  <= wrap ? '0 : (cnt_q + CW'(1));
      end
   end

   assign pulse_o = run_i && (cnt_q < high_q);

endmodule

// File: rtl/rtx_strobe_seq.sv
module rtx_strobe_seq #(
   parameter int ROWS = 256,
   parameter int CW   = 16,
   parameter int WW   = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic            run_i,
   input  logic [CW-1:0]   gap_i,
   input  logic [WW-1:0]   window_i,
   output logic [ROWS-1:0] strobe_o,
   output logic            last_o
);

   localparam int RIW = $clog2(ROWS);
   localparam logic [RIW:0] ROWS_C = (RIW+1)'(ROWS);
   localparam logic [RIW:0] LAST_C = (RIW+1)'(ROWS - 1);

   logic [RIW:0]  head_q;
   logic [RIW:0]  tail_q;
   logic [CW-1:0] gap_q;
   logic [CW-1:0] lcnt_q;
   logic [WW-1:0] rcnt_q;

   // launch counter: opens one new row every gap cycles
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         head_q <= '0;
         lcnt_q <= '0;
         gap_q  <= '0;
      end else if (load_i) begin
         head_q <= (RIW+1)'(1);
         lcnt_q <= '0;
         gap_q  <= gap_i;
      end else if (run_i && head_q != ROWS_C) begin
         if (lcnt_q == gap_q - CW'(1)) begin
            head_q <= head_q + (RIW+1)'(1);
            lcnt_q <= '0;
         end else begin
            lcnt_q <= lcnt_q + CW'(1);
         end
      end
   end

   // retire counter: waits one window, then closes a row every gap cycles
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tail_q <= '0;
         rcnt_q <= '0;
      end else if (load_i) begin
         tail_q <= '0;
         rcnt_q <= window_i - WW'(1);
      end else if (run_i && tail_q != ROWS_C) begin
         if (rcnt_q == '0) begin
            tail_q <= tail_q + (RIW+1)'(1);
            rcnt_q <= WW'(gap_q) - WW'(1);
         end else begin
            rcnt_q <= rcnt_q - WW'(1);
         end
      end
   end

   assign last_o = run_i && (rcnt_q == '0) && (tail_q == LAST_C);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam logic [RIW:0] R_C = (RIW+1)'(r);
      assign strobe_o[r] = run_i && (tail_q <= R_C) && (R_C < head_q);
   end

endmodule

// File: rtl/rtx_row_gate.sv
module rtx_row_gate #(
   parameter int ROWS = 256
) (
   input  logic            pulse_i,
   input  logic [ROWS-1:0] strobe_i,
   output logic [ROWS-1:0] tx_o,
   output logic [ROWS-1:0] txd_o
);

   for (genvar r = 0; r < ROWS; r++) begin : g_gate
      assign tx_o[r]  = pulse_i & strobe_i[r];
      assign txd_o[r] = ~(pulse_i & strobe_i[r]);
   end

endmodule

// File: rtl/rolling_tx_gen.sv
module rolling_tx_gen
   import rolling_tx_pkg::*;
#(
   parameter int ROWS = 256,
   parameter int CW   = 16,
   parameter int NW   = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [CW-1:0]   high_i,
   input  logic [CW-1:0]   period_i,
   input  logic [CW-1:0]   gap_i,
   input  logic [NW-1:0]   pulses_i,
   input  logic [CW-1:0]   phase_i,
   output logic [ROWS-1:0] tx_o,
   output logic [ROWS-1:0] txd_o,
   output logic            done_o
);

   localparam int WW = CW + NW;

   if (ROWS < 2) begin : g_bad_rows
      initial $fatal(1, "rolling_tx_gen: ROWS must be at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      initial $fatal(1, "rolling_tx_gen: CW must be at least 2");
   end
   if (NW < 1) begin : g_bad_nw
      initial $fatal(1, "rolling_tx_gen: NW must be at least 1");
   end

   frame_state_e    state_q;
   frame_state_e    state_d;
   logic            cfg_ok;
   logic            load;
   logic            run;
   logic            pulse;
   logic            last;
   logic [WW-1:0]   window;
   logic [ROWS-1:0] strobe;

   assign cfg_ok = (high_i != '0) && (period_i > high_i) && (gap_i != '0) &&
                   (pulses_i != '0) && (phase_i < period_i);
   assign window = WW'(pulses_i) * WW'(period_i);
   assign load   = (state_q == ST_IDLE) && start_i && cfg_ok;
   assign run    = (state_q == ST_RUN);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (load) state_d = ST_RUN;
         ST_RUN:  if (last) state_d = ST_FIN;
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign done_o = (state_q == ST_FIN);

   rtx_pulse_timer #(.CW(CW)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .run_i    (run),
      .period_i (period_i),
      .high_i   (high_i),
      .phase_i  (phase_i),
      .pulse_o  (pulse)
   );

   rtx_strobe_seq #(.ROWS(ROWS), .CW(CW), .WW(WW)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .run_i    (run),
      .gap_i    (gap_i),
      .window_i (window),
      .strobe_o (strobe),
      .last_o   (last)
   );

   rtx_row_gate #(.ROWS(ROWS)) u_gate (
      .pulse_i  (pulse),
      .strobe_i (strobe),
      .tx_o     (tx_o),
      .txd_o    (txd_o)
   );

endmodule

// File: rtl/rolling_tx_gen_chk.sv
module rolling_tx_gen_chk
   import rolling_tx_pkg::*;
#(
   parameter int ROWS = 256
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            start_i,
   input logic [ROWS-1:0] tx_o,
   input logic [ROWS-1:0] txd_o,
   input logic            done_o,
   input frame_state_e    state_q,
   input logic            cfg_ok
);

   // R5
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R5
   done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (tx_o == '0));

   // R6
   bad_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && start_i && !cfg_ok) |=> (state_q == ST_IDLE && tx_o == '0));

   // R7
   run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && start_i) |=> (state_q != ST_IDLE));

   // R1
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_RUN) |-> (tx_o == '0 && txd_o == '1));

   // R4
   drain_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_o & txd_o) == '0);

endmodule

bind rolling_tx_gen rolling_tx_gen_chk #(.ROWS(ROWS)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .tx_o    (tx_o),
   .txd_o   (txd_o),
   .done_o  (done_o),
   .state_q (state_q),
   .cfg_ok  (cfg_ok)
);

// File: tb/rolling_tx_gen_tb.sv
module rolling_tx_gen_tb_top;

   localparam int ROWS = 8;
   localparam int CW   = 8;
   localparam int NW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [CW-1:0]   high = '0;
   logic [CW-1:0]   period = '0;
   logic [CW-1:0]   gap = '0;
   logic [NW-1:0]   pulses = '0;
   logic [CW-1:0]   phase = '0;
   logic [ROWS-1:0] tx;
   logic [ROWS-1:0] txd;
   logic            done;

   int vectors = 0;
   int fails   = 0;
   int runs    = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rolling_tx_gen #(.ROWS(ROWS), .CW(CW), .NW(NW)) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .start_i  (start),
      .high_i   (high),
      .period_i (period),
      .gap_i    (gap),
      .pulses_i (pulses),
      .phase_i  (phase),
      .tx_o     (tx),
      .txd_o    (txd),
      .done_o   (done)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_quiet(input string tag);
      check(tx == '0, {tag, " tx"}, 32'(tx), 32'd0);
      check(txd == '1, {tag, " txd"}, 32'(txd), 32'(ROWS == 32 ? '1 : ((1 << ROWS) - 1)));
      check(done == 1'b0, {tag, " done"}, 32'(done), 32'd0);
   endtask

   task automatic set_cfg(input int h, input int p, input int g, input int n, input int ph);
      high   = CW'(h);
      period = CW'(p);
      gap    = CW'(g);
      pulses = NW'(n);
      phase  = CW'(ph);
   endtask

   // One frame with every cycle compared; perturb injects changes at k == 3 (R7)
   task automatic run_case(input int h, input int p, input int g, input int n,
                           input int ph, input bit perturb);
      int end_k;
      logic [ROWS-1:0] exp_tx;
      end_k = (ROWS - 1) * g + n * p;
      @(negedge clk);
      set_cfg(h, p, g, n, ph);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k <= end_k + 1; k++) begin
         bit pul;
         // R2: shared pulse with phase shift
         pul = ((k + p - ph) % p) < h;
         for (int r = 0; r < ROWS; r++) begin
            // R3: row window, R4: AND with pulse
            exp_tx[r] = pul && (k >= r * g) && (k < r * g + n * p);
         end
         check(tx == exp_tx,
               $sformatf("R2 R3 R4 %s tx h=%0d p=%0d g=%0d n=%0d ph=%0d k=%0d",
                         (runs > 0) ? "R8" : "", h, p, g, n, ph, k),
               32'(tx), 32'(exp_tx));
         check(txd == ~exp_tx, $sformatf("R4 txd k=%0d", k), 32'(txd), 32'(~exp_tx));
         check(done == (k == end_k), $sformatf("R5 done k=%0d end=%0d", k, end_k),
               32'(done), 32'(k == end_k));
         if (perturb && k == 3) begin
            set_cfg(1, 9, 1, 1, 0);
            start = 1'b1;
         end else if (perturb && k == 4) begin
            start = 1'b0;
            set_cfg(h, p, g, n, ph);
         end
         @(negedge clk);
      end
      runs++;
   endtask

   // R6: an invalid configuration must produce nothing
   task automatic bad_case(input int h, input int p, input int g, input int n, input int ph);
      @(negedge clk);
      set_cfg(h, p, g, n, ph);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 12; k++) begin
         check_quiet($sformatf("R6 h=%0d p=%0d g=%0d n=%0d ph=%0d k=%0d", h, p, g, n, ph, k));
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check_quiet("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_quiet("R1 after reset");

      bad_case(0, 4, 1, 1, 0);
      bad_case(3, 3, 1, 1, 0);
      bad_case(1, 3, 0, 1, 0);
      bad_case(1, 3, 1, 0, 0);
      bad_case(1, 3, 1, 1, 3);

      for (int h = 1; h <= 2; h++) begin
         for (int p = h + 1; p <= 4; p++) begin
            for (int ph = 0; ph < p; ph++) begin
               for (int g = 1; g <= 3; g++) begin
                  for (int n = 1; n <= 2; n++) begin
                     run_case(h, p, g, n, ph, (g == 2));
                  end
               end
            end
         end
      end

      // R8: valid frame directly after an invalid attempt and a finished frame
      bad_case(2, 2, 1, 1, 0);
      run_case(1, 2, 5, 3, 1, 1'b1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule